// File: doc/BRIEF.md
# Retired-Instruction Counter Register Pair

This block holds a 64-bit count of retired instructions for a processor with a 32-bit datapath. Software reaches the count through two 32-bit control registers at separate addresses. One register carries the low word. The other carries the high word. On each cycle the pipeline raises a retire strobe for a retiring instruction. The same instruction may also carry a control-register write or read, presented on an address, a write enable, write data and a read enable.

The block fixes the priority between an explicit write and the automatic increment. A write to either word replaces the whole +1 for that instruction. The word that is not written keeps its old value, so a write to the low word can never carry into the high word. A read returns the count as it stood before the reading instruction's own increment. A value written by one instruction is exactly the value that the next instruction reads.

Top module: `instret_pair`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, both words read as zero.
- R2: With no write to either word, each cycle with the retire strobe high adds one to the full 64-bit count. A carry out of bit 31 reaches the high word at the same clock edge.
- R3: Read data is combinational from the current count. It reflects neither the increment nor the write of the cycle in which it is read.
- R4: A write to the low-word address (default 0x040) loads the write data into bits 31:0 and leaves bits 63:32 unchanged. No increment is applied, even with the retire strobe high.
- R5: A write to the high-word address (default 0x041) loads the write data into bits 63:32 and leaves bits 31:0 unchanged. No increment is applied, even with the retire strobe high.
- R6: A read of a word in the cycle after a write to it returns exactly the written value.
- R7: If the low word holds 0xFFFFFFFF and the high word holds 0, a write of zero to the low word in a retiring cycle leaves the high word at 0.
- R8: Read data is zero when the read enable is low or the address matches neither word. A write to any other address has no effect on the count.
- R9: With no retire strobe and no write to either word, the count holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| retire_i | input | 1 | One instruction retires this cycle |
| csr_addr_i | input | 12 | Control-register address |
| csr_we_i | input | 1 | Write enable |
| csr_wdata_i | input | 32 | Write data |
| csr_re_i | input | 1 | Read enable |
| csr_rdata_o | output | 32 | Read data, combinational |

## Verification
Read data is due in the same cycle as its stimulus, because it is combinational from the register. The effect of a retire or a write is due one clock edge later. The driver applies one instruction's inputs just after a rising edge. It pushes the reference model's pre-update word into the queue and only then advances the model. The monitor samples at the following falling edge, so every compare happens in the same cycle as the stimulus and before the update lands. The effect of each write or increment is then checked by the read in the next instruction.

// File: rtl/instret_pair.sv
module instret_pair #(
  parameter int XLEN   = 32,
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] LO_ADDR = 12'h040,
  parameter logic [ADDR_W-1:0] HI_ADDR = 12'h041
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              retire_i,
  input  logic [ADDR_W-1:0] csr_addr_i,
  input  logic              csr_we_i,
  input  logic [XLEN-1:0]   csr_wdata_i,
  input  logic              csr_re_i,
  output logic [XLEN-1:0]   csr_rdata_o
);
  localparam int CNT_W = 2 * XLEN;

  logic [CNT_W-1:0] cnt_q;
  logic             wr_lo, wr_hi;

  assign wr_lo = csr_we_i && (csr_addr_i == LO_ADDR);
  assign wr_hi = csr_we_i && (csr_addr_i == HI_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (wr_lo)    cnt_q <= {cnt_q[CNT_W-1:XLEN], csr_wdata_i};
    else if (wr_hi)    cnt_q <= {csr_wdata_i, cnt_q[XLEN-1:0]};
    else if (retire_i) cnt_q <= cnt_q + 1'b1;
  end

  assign csr_rdata_o = !csr_re_i               ? '0 :
                       (csr_addr_i == LO_ADDR) ? cnt_q[XLEN-1:0] :
                       (csr_addr_i == HI_ADDR) ? cnt_q[CNT_W-1:XLEN] : '0;

  a_r4_lo_write_keeps_hi: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> (cnt_q[CNT_W-1:XLEN] == $past(cnt_q[CNT_W-1:XLEN])));

  a_r5_hi_write_keeps_lo: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hi |=> (cnt_q[XLEN-1:0] == $past(cnt_q[XLEN-1:0])));

  a_r2_retire_step: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_i && !wr_lo && !wr_hi) |=> (cnt_q - $past(cnt_q) == CNT_W'(1)));

  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!retire_i && !csr_we_i) |=> $stable(cnt_q));

  a_r8_quiet_read: assert property (@(posedge clk) disable iff (!rst_n)
    (!csr_re_i || (csr_addr_i != LO_ADDR && csr_addr_i != HI_ADDR)) |-> (csr_rdata_o == '0));

  a_r6_write_then_read: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo) |=> (cnt_q[XLEN-1:0] == $past(csr_wdata_i)));
endmodule

// File: tb/instret_pair_bench.sv
module instret_pair_bench;
  localparam logic [11:0] LO = 12'h040;
  localparam logic [11:0] HI = 12'h041;
  localparam logic [11:0] XX = 12'h3A7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        retire = 1'b0;
  logic [11:0] addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic        re = 1'b0;
  logic [31:0] rdata;

  int total = 0;
  int bad = 0;
  logic [63:0] model = '0;
  logic [31:0] q_exp [$];
  string       q_tag [$];

  always #5 clk = ~clk;

  instret_pair u_instret_pair (
    .clk(clk), .rst_n(rst_n), .retire_i(retire), .csr_addr_i(addr),
    .csr_we_i(we), .csr_wdata_i(wdata), .csr_re_i(re), .csr_rdata_o(rdata)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input string tag, input logic r, input logic w,
                      input logic [11:0] a, input logic [31:0] d, input logic rd);
    logic [31:0] exp;
    @(posedge clk); #1;
    retire = r; we = w; addr = a; wdata = d; re = rd;
    exp = !rd ? 32'h0 : (a == LO) ? model[31:0] : (a == HI) ? model[63:32] : 32'h0;
    q_exp.push_back(exp);
    q_tag.push_back(tag);
    if (w && a == LO)      model = {model[63:32], d};
    else if (w && a == HI) model = {d, model[31:0]};
    else if (r)            model = model + 64'd1;
  endtask

  always @(negedge clk) begin
    if (q_exp.size() > 0) check(q_tag.pop_front(), rdata, q_exp.pop_front());
  end

  initial begin
    #200000;
    bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    re = 1'b1; addr = LO;
    #12 check("R1 lo in reset", rdata, 32'h0);
    addr = HI;
    #1 check("R1 hi in reset", rdata, 32'h0);
    #10 rst_n = 1'b1;
    step("R1 lo after reset", 0, 0, LO, 0, 1);
    step("R1 hi after reset", 0, 0, HI, 0, 1);
    for (int i = 0; i < 5; i++) step("R3 read pre-increment", 1, 0, LO, 0, 1);
    step("R2 count after retires", 0, 0, LO, 0, 1);
    step("R9 idle", 0, 0, LO, 0, 0);
    step("R9 hold", 0, 0, LO, 0, 1);
    step("R4 write lo", 1, 1, LO, 32'hFFFF_FFFE, 1);
    step("R6 lo readback", 1, 0, LO, 0, 1);
    step("R2 hi before carry", 1, 0, HI, 0, 1);
    step("R2 carry into hi", 0, 0, HI, 0, 1);
    step("R2 lo wrapped", 0, 0, LO, 0, 1);
    step("R5 clear hi", 0, 1, HI, 0, 0);
    step("R4 preload lo", 0, 1, LO, 32'hFFFF_FFFF, 0);
    step("R7 write zero lo with retire", 1, 1, LO, 0, 1);
    step("R7 hi stays zero", 0, 0, HI, 0, 1);
    step("R7 lo is zero", 0, 0, LO, 0, 1);
    step("R4 lo=5", 0, 1, LO, 5, 0);
    step("R5 write hi with retire", 1, 1, HI, 32'h0000_00AB, 1);
    step("R5 lo unchanged", 0, 0, LO, 0, 1);
    step("R6 hi readback", 0, 0, HI, 0, 1);
    step("R8 bad addr read", 1, 0, XX, 0, 1);
    step("R8 bad addr write", 1, 1, XX, 32'h1234_5678, 0);
    step("R8 lo after bad write", 0, 0, LO, 0, 1);
    step("R8 re low", 0, 0, HI, 0, 0);
    for (int i = 0; i < 300; i++) begin
      logic [1:0] s;
      logic [11:0] a;
      s = 2'($urandom_range(0, 3));
      a = (s == 0) ? LO : (s == 1) ? HI : (s == 2) ? XX : LO;
      step("R2 R4 R5 R6 mixed", 1'($urandom), ($urandom_range(0, 5) == 0),
           a, ($urandom_range(0, 1) == 0) ? 32'hFFFF_FFFF : $urandom, 1'($urandom));
    end
    step("R6 final lo", 0, 0, LO, 0, 1);
    step("R6 final hi", 0, 0, HI, 0, 1);
    @(posedge clk); @(posedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule